// File: doc/BRIEF.md
# Six-Button Gamepad Port Multiplexer

This block models one controller port of a games console as seen by the host processor. The host writes a data register and a direction register, and reads back a 7-bit port value with the data register's top bit above it. Bit 6 of the data register acts as the select line (TH). It chooses which group of the twelve buttons appears in the low six bits of the read value.

With six-button mode enabled, every rising edge of the select line caused by a host write moves a small phase counter forward. In phases 2 and 3 the read value takes special patterns: an all-zero marker, an all-one marker, and the X/Y/Z/Mode buttons in place of the direction pad. The phase counter stops at 3. An idle timer clears it after a programmable number of cycles with no data write. When six-button mode is off, the port behaves as a plain three-button pad.

Top module: `sixpad_port_mux`

## Requirements
- R1: After reset the data and direction registers hold 0 and the phase is 0. With no button pressed, rd_data reads 8'h33.
- R2: btn_pressed is active high, with bit 0 Up, 1 Down, 2 Left, 3 Right, 4 B, 5 C, 6 A, 7 Start, 8 Z, 9 Y, 10 X and 11 Mode. A pressed button reads as 0 and a released one reads as 1.
- R3: In the normal read pattern with TH (data bit 6) high, bits 5:0 are {C, B, Right, Left, Down, Up}.
- R4: In the normal read pattern with TH low, bits 5:0 are {Start, A, 0, 0, Down, Up}.
- R5: With six_btn_en high, a data write that takes bit 6 from 0 to 1 advances the phase by one. A write that leaves bit 6 at 1, or clears it, does not advance the phase.
- R6: With six_btn_en low the phase never advances, and only the normal patterns (R3, R4) are returned.
- R7: In phase 2 with TH low, bits 5:0 are {Start, A, 0, 0, 0, 0}.
- R8: In phase 3 with TH high, bits 5:0 are {C, B, Mode, X, Y, Z}.
- R9: In phase 3 with TH low, bits 5:0 are {Start, A, 1, 1, 1, 1}.
- R10: The phase stays at 3 on further rising edges and does not wrap.
- R11: Each rd_data bit whose direction-register bit is 1 is ORed with the data-register bit. Bit 6 is otherwise 0.
- R12: rd_data bit 7 always equals data-register bit 7.
- R13: Every data write clears the idle counter. After TIMEOUT cycles with no data write, the next clock edge returns the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| six_btn_en | input | 1 | Enables the six-button phase sequence |
| btn_pressed | input | 12 | Button states, 1 = pressed (order in R2) |
| data_we | input | 1 | Host write strobe for the data register |
| dir_we | input | 1 | Host write strobe for the direction register |
| wdata | input | 8 | Host write data |
| rd_data | output | 8 | Port read value |

## Verification
rd_data is combinational from the registers and the live buttons. A button change therefore shows in the same cycle, and a register write shows after the next clock edge. The phase clear from R13 lands on the edge TIMEOUT+1 cycles after the edge that took the last data write. The bench drives inputs just after the falling edge and keeps a behavioural model that updates on each rising edge. It compares rd_data at every falling edge, so each result is sampled exactly one edge after the write that caused it. Directed checks with literal expected values sit at the cycles on either side of the timeout edge and at each phase of the sequence.

// File: rtl/sixpad_port_mux.sv
module sixpad_port_mux #(
  parameter int TIMEOUT = 64,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        six_btn_en,
  input  logic [11:0] btn_pressed,
  input  logic        data_we,
  input  logic        dir_we,
  input  logic [7:0]  wdata,
  output logic [7:0]  rd_data
);

  logic [7:0]    data_q, dir_q;
  logic [1:0]    phase_q;
  logic [CW-1:0] idle_q;
  logic [5:0]    pat;

  wire        th      = data_q[6];
  wire [11:0] lvl     = ~btn_pressed;
  wire        th_rise = data_we & ~th & wdata[6];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      dir_q   <= '0;
      phase_q <= '0;
      idle_q  <= '0;
    end else begin
      if (dir_we) dir_q <= wdata;
      if (data_we) begin
        data_q <= wdata;
        idle_q <= '0;
        if (six_btn_en && th_rise && phase_q != 2'd3) phase_q <= 2'(phase_q + 2'd1);
      end else if (idle_q == CW'(TIMEOUT)) begin
        phase_q <= '0;
      end else begin
        idle_q <= CW'(idle_q + 1'b1);
      end
    end
  end

  always_comb begin
    if (six_btn_en && phase_q == 2'd3 && th)
      pat = {lvl[5], lvl[4], lvl[11], lvl[10], lvl[9], lvl[8]};
    else if (six_btn_en && phase_q == 2'd3)
      pat = {lvl[7], lvl[6], 4'hF};
    else if (six_btn_en && phase_q == 2'd2 && !th)
      pat = {lvl[7], lvl[6], 4'h0};
    else if (th)
      pat = lvl[5:0];
    else
      pat = {lvl[7], lvl[6], 2'b00, lvl[1], lvl[0]};
  end

  assign rd_data = {data_q[7], 1'b0, pat} | (data_q & dir_q);

endmodule

module sixpad_port_mux_chk #(
  parameter int TIMEOUT = 64,
  localparam int CW = $clog2(TIMEOUT + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          six_btn_en,
  input logic          data_we,
  input logic [7:0]    wdata,
  input logic [7:0]    data_q,
  input logic [1:0]    phase_q,
  input logic [CW-1:0] idle_q,
  input logic [7:0]    rd_data
);

  // R5
  phase_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    six_btn_en && data_we && !data_q[6] && wdata[6] && phase_q != 2'd3 |=> phase_q == $past(phase_q) + 2'd1);

  // R6
  no_advance_three_btn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !six_btn_en && data_we |=> $stable(phase_q));

  // R10
  phase_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q == 2'd3 && data_we |=> phase_q == 2'd3);

  // R13
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |=> idle_q == '0);

  // R13
  timeout_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !data_we && idle_q == CW'(TIMEOUT) |=> phase_q == 2'd0);

  // R12
  top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == data_q[7]);

endmodule

bind sixpad_port_mux sixpad_port_mux_chk #(.TIMEOUT(TIMEOUT)) chk (.*);

// File: tb/sixpad_port_mux_test.sv
module sixpad_port_mux_test;
  localparam int TO = 20;

  logic clk = 0, rst_n = 0, six_btn_en = 0, data_we = 0, dir_we = 0;
  logic [11:0] btn_pressed = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rd_data;
  int vectors = 0, fails = 0;
  bit running = 1;

  sixpad_port_mux #(.TIMEOUT(TO)) uut (.*);

  always #5 clk = ~clk;

  int m_data = 0, m_dir = 0, m_phase = 0, m_cnt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data <= 0; m_dir <= 0; m_phase <= 0; m_cnt <= 0;
    end else begin
      if (dir_we) m_dir <= wdata;
      if (data_we) begin
        m_cnt <= 0;
        if (six_btn_en && m_data[6] == 0 && wdata[6] && m_phase < 3) m_phase <= m_phase + 1;
        m_data <= wdata;
      end else if (m_cnt >= TO) m_phase <= 0;
      else m_cnt <= m_cnt + 1;
    end
  end

  function automatic bit up(int i); return !btn_pressed[i]; endfunction

  function automatic logic [7:0] model_rd();
    logic [5:0] p;
    bit th = m_data[6];
    if (six_btn_en && m_phase == 3 && th) p = {up(5), up(4), up(11), up(10), up(9), up(8)};
    else if (six_btn_en && m_phase == 3) p = {up(7), up(6), 4'hF};
    else if (six_btn_en && m_phase == 2 && !th) p = {up(7), up(6), 4'h0};
    else if (th) p = {up(5), up(4), up(3), up(2), up(1), up(0)};
    else p = {up(7), up(6), 2'b00, up(1), up(0)};
    return ({m_data[7], 1'b0, p} | 8'(m_data & m_dir));
  endfunction

  function automatic string model_tag();
    if (m_data[6:0] & m_dir[6:0]) return "R11";
    if (six_btn_en && m_phase == 3) return m_data[6] ? "R8" : "R9";
    if (six_btn_en && m_phase == 2 && !m_data[6]) return "R7";
    if (!six_btn_en) return "R6";
    return m_data[6] ? "R3" : "R4";
  endfunction

  always @(negedge clk) if (rst_n && running) begin
    logic [7:0] e;
    e = model_rd();
    vectors++;
    if (rd_data !== e) begin
      fails++;
      $display("FAIL %s model compare: rd_data=%h expected=%h t=%0t", model_tag(), rd_data, e, $time);
    end
  end

  task automatic check(string tag, logic [7:0] exp);
    vectors++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); #1; data_we = 1; wdata = v;
    @(negedge clk); #1; data_we = 0;
  endtask

  task automatic wdir(logic [7:0] v);
    @(negedge clk); #1; dir_we = 1; wdata = v;
    @(negedge clk); #1; dir_we = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #1;
    check("R1 reset", 8'h33);
    btn_pressed = 12'h001; #1;
    check("R2 up pressed", 8'h32);
    btn_pressed = '0;
    wr(8'h40); check("R3 th high idle", 8'h3F);
    btn_pressed = 12'h020; #1; check("R3 C pressed", 8'h1F);
    btn_pressed = '0;
    wr(8'hC0); check("R12 bit7", 8'hBF);
    for (int i = 0; i < 4; i++) begin wr(8'h00); wr(8'h40); end
    check("R6 no extended", 8'h3F);
    wr(8'h00);
    #1 six_btn_en = 1;
    btn_pressed = 12'h400; #1; check("R6 phase held at 0", 8'h33);
    wr(8'h40); check("R5 phase1 th high", 8'h3F);
    wr(8'h40); wr(8'h00); check("R5 phase1 th low", 8'h33);
    wr(8'h40); btn_pressed = 12'h040;
    wr(8'h00); check("R7 phase2 th low", 8'h20);
    btn_pressed = 12'h900;
    wr(8'h40); check("R8 phase3 th high", 8'h36);
    btn_pressed = 12'h080;
    wr(8'h00); check("R9 phase3 th low", 8'h1F);
    btn_pressed = 12'h200;
    wr(8'h40); check("R10 saturated", 8'h3D);
    repeat (TO) @(negedge clk);
    #1 check("R13 before timeout", 8'h3D);
    @(negedge clk); #1 check("R13 after timeout", 8'h3F);
    wr(8'h00); wr(8'h40); check("R13 restart phase1", 8'h3F);
    wr(8'h00); wr(8'h40); wr(8'h00); check("R13 restart phase2", 8'h00 | 8'h30);
    #1 six_btn_en = 0; btn_pressed = '0;
    wdir(8'h0F); wr(8'h05); check("R11 dir or", 8'h37);
    wdir(8'h40); wr(8'h40); check("R11 bit6 out", 8'h7F);
    wdir(8'h00);
    #1 six_btn_en = 1;
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk); #1;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      btn_pressed = lf[11:0];
      data_we = (lf[3:0] < 6);
      dir_we = (lf[7:4] == 0);
      wdata = {lf[15], lf[9] ^ lf[2], lf[5:0]};
      if (lf[15:12] == 4'hF) six_btn_en = ~six_btn_en;
      if (n % 700 == 699) begin data_we = 0; dir_we = 0; repeat (TO + 3) @(negedge clk); #1; end
    end
    @(negedge clk); #1 data_we = 0; dir_we = 0;
    repeat (3) @(negedge clk);
    running = 0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule